// File: doc/BRIEF.md
# Two-Tap Fixed-Point FIR Filter with Selectable Structure

This block filters a stream of 4-bit unsigned samples with a two-tap finite impulse response. Every accepted sample x(n) produces one result y(n) = h0·x(n) + h1·x(n-1). The two 4-bit unsigned coefficients sit in a small coefficient bank that is written through a one-word write port. They are meant to stay unchanged while samples stream.

An elaboration parameter picks the internal structure. The direct structure keeps a delay line of past samples at the multiplier inputs. The transposed structure multiplies each new sample by every coefficient and keeps the delayed partial sums in registers inside the adder chain. Both structures register the result once, so they produce the same output sequence with the same one-cycle latency. Each tap has its own single-cycle array multiplier built from AND-gate partial products. Those rows are compressed by carry-save stages and then resolved by one final adder.

A sample counts only in a cycle where its valid strobe is high. Cycles without valid neither advance the filter history nor change the held output.

Top module: `fir2_filter`

## Requirements
- R1: A synchronous, active-high `rst` clears the sample history, the partial sums, both coefficients and the output. In the cycle after reset, `out_valid` is 0 and `out_y` is 0.
- R2: `out_valid` is high in exactly the cycles that follow a clock edge where `in_valid` was high and `rst` was low.
- R3: When `out_valid` is high, `out_y` equals h0·x(n) + h1·x(n-1) as a 9-bit unsigned value, with no wrap. The largest possible value is 450.
- R4: Only samples accepted with `in_valid` high enter the history. Cycles without valid between two samples leave x(n-1) unchanged.
- R5: `out_y` keeps its value in every cycle that follows an edge without valid.
- R6: The first sample after reset is combined with a history sample of 0.
- R7: A write with `coef_we` high stores `coef_wdata` into h0 when `coef_sel` is 0 and into h1 when `coef_sel` is 1. The new value applies to samples accepted from the next edge on.
- R8: With `FORM` set to direct (0) or transposed (1), the block gives the same `out_valid`/`out_y` sequence for the same inputs, provided the coefficients are written before the first sample after reset.
- R9: Each tap product is fully formed within the same cycle, for all 16×16 operand pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 1 | Coefficient index: 0 selects h0, 1 selects h1 |
| coef_wdata | input | 4 | Coefficient value to write |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 4 | Unsigned input sample |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_y | output | 9 | Unsigned filter result |

## Verification
The bench sends identical stimulus to a direct and a transposed instance and compares both against a queue-based convolution model on every clock. It drives all-maximum operands, so a product or sum that is one bit too narrow wraps the result below 450. Gaps in `in_valid` inside a stream catch a history register that shifts on idle cycles, and that error shows up as a wrong x(n-1) term. Samples fed right after reset catch stale history or a coefficient bank that reset does not clear. An exhaustive sweep of multiplier operands exposes any missing or misplaced partial-product row.

// File: rtl/fir2_pkg.sv
`timescale 1ns/1ps
package fir2_pkg;
   localparam int NTAPS = 2;

   typedef enum logic {
      FORM_DIRECT     = 1'b0,
      FORM_TRANSPOSED = 1'b1
   } fir2_form_e;

   function automatic int acc_width(input int prod_w, input int taps);
      return prod_w + $clog2(taps);
   endfunction

   function automatic int sel_width(input int taps);
      return (taps > 1) ? $clog2(taps) : 1;
   endfunction
endpackage

// File: rtl/fir2_tree_mul.sv
`timescale 1ns/1ps
module fir2_tree_mul #(
   parameter int AW = 4,
   parameter int BW = 4
) (
   input  logic [AW-1:0]    op_a,
   input  logic [BW-1:0]    op_b,
   output logic [AW+BW-1:0] prod
);
   localparam int PW = AW + BW;

   logic [PW-1:0] pp_row [BW];
   logic [PW-1:0] sum_row [BW];
   logic [PW-1:0] car_row [BW];

   // Partial products: operand A gated by each bit of B, shifted by its weight.
   for (genvar i = 0; i < BW; i++) begin : g_pp
      assign pp_row[i] = PW'({AW{op_b[i]}} & op_a) << i;
   end

   // Carry-save compression: each stage folds one more row with no carry ripple.
   assign sum_row[0] = pp_row[0];
   assign car_row[0] = '0;
   for (genvar i = 1; i < BW; i++) begin : g_csa
      assign sum_row[i] = sum_row[i-1] ^ car_row[i-1] ^ pp_row[i];
      assign car_row[i] = ((sum_row[i-1] & car_row[i-1]) |
                           (sum_row[i-1] & pp_row[i])    |
                           (car_row[i-1] & pp_row[i])) << 1;
   end

   // Single carry-propagate add resolves the redundant pair.
   assign prod = sum_row[BW-1] + car_row[BW-1];
endmodule

// File: rtl/fir2_coef_bank.sv
`timescale 1ns/1ps
module fir2_coef_bank #(
   parameter int CW   = 4,
   parameter int N    = 2,
   parameter int SELW = 1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  wr_en,
   input  logic [SELW-1:0]       wr_idx,
   input  logic [CW-1:0]         wr_val,
   output logic [N-1:0][CW-1:0]  coefs
);
   always_ff @(posedge clk) begin
      if (rst) begin
         coefs <= '0;
      end else if (wr_en) begin
         for (int k = 0; k < N; k++) begin
            if (wr_idx == SELW'(k)) coefs[k] <= wr_val;
         end
      end
   end
endmodule

// File: rtl/fir2_direct_core.sv
`timescale 1ns/1ps
module fir2_direct_core #(
   parameter int SW = 4,
   parameter int CW = 4,
   parameter int N  = 2,
   parameter int YW = 9
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [SW-1:0]        in_sample,
   input  logic [N-1:0][CW-1:0] coefs,
   output logic                 out_valid,
   output logic [YW-1:0]        out_y
);
   localparam int PW = SW + CW;

   logic [SW-1:0] hist_q [N-1];
   logic [SW-1:0] tap_x  [N];
   logic [PW-1:0] tap_p  [N];
   logic [YW-1:0] acc;

   for (genvar k = 0; k < N; k++) begin : g_tap
      if (k == 0) begin : g_head
         assign tap_x[k] = in_sample;
      end else begin : g_line
         assign tap_x[k] = hist_q[k-1];
      end
      fir2_tree_mul #(.AW(SW), .BW(CW)) mul_i (
         .op_a (tap_x[k]),
         .op_b (coefs[k]),
         .prod (tap_p[k])
      );
   end

   always_comb begin
      acc = '0;
      for (int k = 0; k < N; k++) acc = acc + YW'(tap_p[k]);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < N-1; k++) hist_q[k] <= '0;
         out_valid <= 1'b0;
         out_y     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            hist_q[0] <= in_sample;
            for (int k = 1; k < N-1; k++) hist_q[k] <= hist_q[k-1];
            out_y <= acc;
         end
      end
   end
endmodule

// File: rtl/fir2_transposed_core.sv
`timescale 1ns/1ps
module fir2_transposed_core #(
   parameter int SW = 4,
   parameter int CW = 4,
   parameter int N  = 2,
   parameter int YW = 9
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [SW-1:0]        in_sample,
   input  logic [N-1:0][CW-1:0] coefs,
   output logic                 out_valid,
   output logic [YW-1:0]        out_y
);
   localparam int PW = SW + CW;

   logic [PW-1:0] tap_p  [N];
   logic [YW-1:0] part_q [N-1];
   logic [YW-1:0] part_in [N-1];

   for (genvar k = 0; k < N; k++) begin : g_tap
      fir2_tree_mul #(.AW(SW), .BW(CW)) mul_i (
         .op_a (in_sample),
         .op_b (coefs[k]),
         .prod (tap_p[k])
      );
   end

   // Next value of each partial-sum register: own product plus the one above.
   for (genvar j = 0; j < N-1; j++) begin : g_part
      if (j == N-2) begin : g_top
         assign part_in[j] = YW'(tap_p[j+1]);
      end else begin : g_mid
         assign part_in[j] = YW'(tap_p[j+1]) + part_q[j+1];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int j = 0; j < N-1; j++) part_q[j] <= '0;
         out_valid <= 1'b0;
         out_y     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            for (int j = 0; j < N-1; j++) part_q[j] <= part_in[j];
            out_y <= YW'(tap_p[0]) + part_q[0];
         end
      end
   end
endmodule

// File: rtl/fir2_filter.sv
`timescale 1ns/1ps
module fir2_filter #(
   parameter int                   SW   = 4,
   parameter int                   CW   = 4,
   parameter fir2_pkg::fir2_form_e FORM = fir2_pkg::FORM_DIRECT,
   localparam int N    = fir2_pkg::NTAPS,
   localparam int SELW = fir2_pkg::sel_width(fir2_pkg::NTAPS),
   localparam int YW   = fir2_pkg::acc_width(SW + CW, fir2_pkg::NTAPS)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            coef_we,
   input  logic [SELW-1:0] coef_sel,
   input  logic [CW-1:0]   coef_wdata,
   input  logic            in_valid,
   input  logic [SW-1:0]   in_sample,
   output logic            out_valid,
   output logic [YW-1:0]   out_y
);
   if (SW < 1 || CW < 1) begin : g_bad_width
      $error("fir2_filter: sample and coefficient widths must be positive");
   end
   if (N < 2) begin : g_bad_taps
      $error("fir2_filter: at least two taps required");
   end

   logic [N-1:0][CW-1:0] coefs;

   fir2_coef_bank #(.CW(CW), .N(N), .SELW(SELW)) bank_i (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (coef_we),
      .wr_idx (coef_sel),
      .wr_val (coef_wdata),
      .coefs  (coefs)
   );

   if (FORM == fir2_pkg::FORM_TRANSPOSED) begin : g_transposed
      fir2_transposed_core #(.SW(SW), .CW(CW), .N(N), .YW(YW)) core_i (
         .clk       (clk),
         .rst       (rst),
         .in_valid  (in_valid),
         .in_sample (in_sample),
         .coefs     (coefs),
         .out_valid (out_valid),
         .out_y     (out_y)
      );
   end else begin : g_direct
      fir2_direct_core #(.SW(SW), .CW(CW), .N(N), .YW(YW)) core_i (
         .clk       (clk),
         .rst       (rst),
         .in_valid  (in_valid),
         .in_sample (in_sample),
         .coefs     (coefs),
         .out_valid (out_valid),
         .out_y     (out_y)
      );
   end
endmodule

// File: rtl/fir2_filter_chk.sv
`timescale 1ns/1ps
module fir2_filter_chk #(
   parameter int SW = 4,
   parameter int CW = 4,
   parameter int YW = 9
) (
   input logic          clk,
   input logic          rst,
   input logic          in_valid,
   input logic          out_valid,
   input logic [YW-1:0] out_y
);
   localparam int MAXY = fir2_pkg::NTAPS * ((2**SW) - 1) * ((2**CW) - 1);

   p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!out_valid && out_y == '0));

   p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (int'(out_y) <= MAXY));

   p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_y));
endmodule

bind fir2_filter fir2_filter_chk #(.SW(SW), .CW(CW), .YW(YW)) chk_i (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_y     (out_y)
);

// File: tb/fir2_filter_tb_top.sv
`timescale 1ns/1ps
module fir2_filter_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       coef_we = 1'b0;
   logic [0:0] coef_sel = 1'b0;
   logic [3:0] coef_wdata = '0;
   logic       in_valid = 1'b0;
   logic [3:0] in_sample = '0;
   logic       ov_d, ov_t;
   logic [8:0] y_d, y_t;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // Behavioural model state
   int h[2];
   int hist[$];
   int exp_y = 0;
   bit exp_v = 0;

   always #10 clk = ~clk;

   fir2_filter #(.FORM(fir2_pkg::FORM_DIRECT)) dut_i (
      .clk(clk), .rst(rst), .coef_we(coef_we), .coef_sel(coef_sel),
      .coef_wdata(coef_wdata), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(ov_d), .out_y(y_d));

   fir2_filter #(.FORM(fir2_pkg::FORM_TRANSPOSED)) dut_t (
      .clk(clk), .rst(rst), .coef_we(coef_we), .coef_sel(coef_sel),
      .coef_wdata(coef_wdata), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(ov_t), .out_y(y_t));

   task automatic check(string tag, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s got=%0d exp=%0d t=%0t", tag, got, exp, $time);
      end
   endtask

   task automatic compare(string tag);
      check({tag, " direct valid"}, int'(ov_d), int'(exp_v));
      check({tag, " direct y"}, int'(y_d), exp_y);
      check({tag, " transposed valid"}, int'(ov_t), int'(exp_v));
      check({tag, " transposed y"}, int'(y_t), exp_y);
   endtask

   // Called at a negedge; returns at the next negedge after comparing.
   task automatic do_reset();
      rst = 1'b1; in_valid = 1'b0; coef_we = 1'b0;
      @(posedge clk);
      hist = {0}; h[0] = 0; h[1] = 0; exp_y = 0; exp_v = 0;
      @(negedge clk);
      rst = 1'b0;
      compare("R1");
   endtask

   task automatic wr_coef(int sel, int val, string tag);
      coef_we = 1'b1; coef_sel = 1'(sel); coef_wdata = 4'(val);
      @(posedge clk);
      h[sel] = val; exp_v = 0;
      @(negedge clk);
      coef_we = 1'b0;
      compare(tag);
   endtask

   task automatic sample(bit v, int x, string tag);
      in_valid = v; in_sample = 4'(x);
      @(posedge clk);
      if (v) begin
         exp_y = h[0] * x + h[1] * hist[0];
         hist[0] = x;
         exp_v = 1;
      end else begin
         exp_v = 0;
      end
      @(negedge clk);
      in_valid = 1'b0;
      compare(tag);
   endtask

   initial begin
      hist = {0};
      h[0] = 0; h[1] = 0;
      @(negedge clk);
      @(negedge clk);
      do_reset();                         // R1 reset state

      // R7: h1 written alone, h0 left at zero
      wr_coef(1, 7, "R7");
      sample(1, 2, "R6 R7");              // 0*2 + 7*0 = 0
      sample(1, 3, "R7");                 // 0*3 + 7*2 = 14
      wr_coef(0, 5, "R7");

      // R6: first sample after reset sees zero history
      do_reset();
      wr_coef(0, 9, "R7");
      wr_coef(1, 11, "R7");
      sample(1, 6, "R6");                 // 54
      sample(1, 4, "R3");                 // 36 + 66 = 102

      // R4/R5: gaps keep history and output
      sample(0, 15, "R5");
      sample(0, 1, "R5");
      sample(1, 1, "R4");                 // 9 + 44 = 53
      sample(0, 0, "R5");
      sample(1, 0, "R4");                 // 0 + 11 = 11

      // R3: maximum operands, 450 must not wrap
      do_reset();
      wr_coef(0, 15, "R7");
      wr_coef(1, 15, "R7");
      sample(1, 15, "R3");
      sample(1, 15, "R3 max");
      sample(1, 0, "R3");

      // R9: exhaustive product sweep through tap 0 and tap 1
      for (int c = 0; c < 16; c++) begin
         do_reset();
         wr_coef(0, c, "R9");
         wr_coef(1, 15 - c, "R9");
         for (int x = 0; x < 16; x++) sample(1, x, "R9");
         for (int x = 15; x >= 0; x--) sample(1, x, "R9");
      end

      // R8/R2: random streams with random gaps, both structures vs model
      for (int blk = 0; blk < 40; blk++) begin
         do_reset();
         wr_coef(0, int'($urandom_range(0, 15)), "R7");
         wr_coef(1, int'($urandom_range(0, 15)), "R7");
         for (int i = 0; i < 60; i++)
            sample(bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, 15)), "R8 R2");
      end

      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog expired got=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule